// File: doc/BRIEF.md
# UART Modem Loopback Controller

This block implements the internal self-test path of a UART. While the loopback mode bit of the control register is set, the software-driven modem control outputs are fed straight back onto the modem status flags. The same update raises the matching modem-status interrupt bits. Characters and break requests that software sends are redirected into the receive FIFO, and anything arriving from the external receive line is thrown away. When loopback is off, the block passes external receive traffic on to the FIFO and leaves the modem flags alone.

It sits between the register file and the receive FIFO. The register file presents the value being written to the control register together with a write strobe. It also presents transmit-data writes and line-control writes that carry the send-break bit. The block drives one FIFO push port, which marks break entries, and it drives a set/clear vector for the four modem-status interrupt bits. Every output is registered, so a result appears in the cycle after the write that causes it. Serial bit timing and hardware flow control are handled elsewhere.

Top module: `uart_loopback_ctl`

## Requirements
- R1: After reset, all four modem flags are 0, both interrupt vectors are 0, no push is issued, loopback is off and the stored send-break bit is 0.
- R2: A control write with the loopback bit set updates the flags in the following cycle as follows: ring indicator takes Out2, carrier detect takes Out1, clear-to-send takes request-to-send, and data-set-ready takes data-terminal-ready. This includes the write that first turns loopback on.
- R3: The flags keep their values across a control write with the loopback bit clear and across cycles with no control write.
- R4: In the cycle after a control write with the loopback bit set, ms_irq_clr is 4'b1111 and ms_irq_set holds a 1 for each flag that is now high, with bit 0 = ring indicator, bit 1 = clear-to-send, bit 2 = carrier detect and bit 3 = data-set-ready. In all other cycles both vectors are 0.
- R5: In loopback, a transmit-data write pushes its byte into the FIFO in the next cycle, with the break mark at 0.
- R6: A line-control write whose send-break bit goes from 0 to 1 while loopback is on pushes one break entry (break mark 1, data 0). A line-control write that leaves the bit at 1 pushes nothing, and neither does a write that clears it. Every line-control write updates the stored bit, whether loopback is on or off.
- R7: When a transmit byte and a break edge are requested in the same cycle, the byte is pushed in the next cycle and the break entry in the cycle after that.
- R8: While loopback is on, external characters and external breaks produce no push.
- R9: While loopback is off, an external character is pushed in the next cycle with its data and break mark, and transmit-data writes and break edges push nothing.
- R10: A push request made in a cycle when fifo_full is high is dropped and never issued later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_lbe | input | 1 | Loopback enable bit of the written control value |
| ctrl_out1 | input | 1 | Out1 bit of the written control value |
| ctrl_out2 | input | 1 | Out2 bit of the written control value |
| ctrl_rts | input | 1 | Request-to-send bit of the written control value |
| ctrl_dtr | input | 1 | Data-terminal-ready bit of the written control value |
| tx_wr | input | 1 | Transmit-data write strobe |
| tx_data | input | DATA_W | Transmit byte |
| lcr_wr | input | 1 | Line-control write strobe |
| lcr_brk | input | 1 | Send-break bit of the written line-control value |
| ext_valid | input | 1 | External receive entry valid |
| ext_data | input | DATA_W | External receive character |
| ext_break | input | 1 | External entry is a break |
| fifo_full | input | 1 | Receive FIFO cannot accept an entry this cycle |
| push_valid | output | 1 | FIFO push strobe |
| push_data | output | DATA_W | FIFO push character |
| push_break | output | 1 | FIFO push entry is a break |
| flag_ri | output | 1 | Ring indicator flag |
| flag_dcd | output | 1 | Carrier detect flag |
| flag_cts | output | 1 | Clear-to-send flag |
| flag_dsr | output | 1 | Data-set-ready flag |
| ms_irq_set | output | 4 | Modem-status interrupt bits to set |
| ms_irq_clr | output | 4 | Modem-status interrupt bits to clear |

## Verification
The assertions assume that the register file never issues a transmit-data write in the cycle right after a collision between a transmit byte and a break edge. In that cycle the deferred break owns the push port, so the assertion on transmit pushes only applies when no deferred break is waiting. They also treat fifo_full as valid in the same cycle as the request it gates. The stimulus keeps to both assumptions: after each collision it leaves one idle cycle, and it raises fifo_full only alongside the single request it is meant to block.

// File: rtl/ulb_pkg.sv
package ulb_pkg;

  localparam int MS_W = 4;

  // packed order puts ring indicator at bit 0, data-set-ready at bit 3
  typedef struct packed {
    logic dsr;
    logic dcd;
    logic cts;
    logic ri;
  } modem_flags_t;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_PEND,
    SRC_TX,
    SRC_BRK,
    SRC_EXT
  } push_src_e;

endpackage

// File: rtl/ulb_modem_mirror.sv
module ulb_modem_mirror
  import ulb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             ctrl_lbe,
  input  logic             ctrl_out1,
  input  logic             ctrl_out2,
  input  logic             ctrl_rts,
  input  logic             ctrl_dtr,
  output modem_flags_t     flags,
  output logic [MS_W-1:0]  ms_set,
  output logic [MS_W-1:0]  ms_clr
);

  modem_flags_t    flags_q, flags_d;
  logic [MS_W-1:0] set_q, set_d, clr_q, clr_d;
  logic            upd;

  assign upd = ctrl_wr && ctrl_lbe;

  always_comb begin
    flags_d = flags_q;
    set_d   = '0;
    clr_d   = '0;
    if (upd) begin
      flags_d.ri  = ctrl_out2;
      flags_d.dcd = ctrl_out1;
      flags_d.cts = ctrl_rts;
      flags_d.dsr = ctrl_dtr;
      clr_d       = '1;
      set_d       = flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      set_q   <= '0;
      clr_q   <= '0;
    end else begin
      if (upd) flags_q <= flags_d;
      set_q <= set_d;
      clr_q <= clr_d;
    end
  end

  assign flags  = flags_q;
  assign ms_set = set_q;
  assign ms_clr = clr_q;

  assert_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_lbe) |=> (flags.ri == $past(ctrl_out2)) && (flags.dcd == $past(ctrl_out1))
                              && (flags.cts == $past(ctrl_rts)) && (flags.dsr == $past(ctrl_dtr)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_wr && ctrl_lbe) |=> $stable(flags));

  assert_irq_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_clr != '0) |-> (ms_clr == '1) && (ms_set == flags));

  assert_irq_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_wr && ctrl_lbe) |=> (ms_clr == '0) && (ms_set == '0));

endmodule

// File: rtl/ulb_push_sel.sv
module ulb_push_sel
  import ulb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lbe,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              brk_edge,
  input  logic              ext_valid,
  input  logic [DATA_W-1:0] ext_data,
  input  logic              ext_break,
  input  logic              fifo_full,
  output logic              push_valid,
  output logic [DATA_W-1:0] push_data,
  output logic              push_break
);

  localparam logic [DATA_W-1:0] BRK_DATA = '0;

  logic              tx_req, brk_req, ext_req;
  logic              pend_q, pend_d;
  push_src_e         src;
  logic              pv_q, pv_d;
  logic [DATA_W-1:0] pd_q, pd_d;
  logic              pb_q, pb_d;

  assign tx_req  = lbe && tx_wr;
  assign brk_req = lbe && brk_edge;
  assign ext_req = !lbe && ext_valid;

  always_comb begin
    if (pend_q)       src = SRC_PEND;
    else if (tx_req)  src = SRC_TX;
    else if (brk_req) src = SRC_BRK;
    else if (ext_req) src = SRC_EXT;
    else              src = SRC_NONE;
  end

  always_comb begin
    pend_d = brk_req && (src != SRC_BRK);
    pd_d   = pd_q;
    pb_d   = 1'b0;
    case (src)
      SRC_PEND, SRC_BRK: begin pd_d = BRK_DATA; pb_d = 1'b1;      end
      SRC_TX:            begin pd_d = tx_data;  pb_d = 1'b0;      end
      SRC_EXT:           begin pd_d = ext_data; pb_d = ext_break; end
      default:           ;
    endcase
    pv_d = (src != SRC_NONE) && !fifo_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pv_q   <= 1'b0;
      pd_q   <= '0;
      pb_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      pv_q   <= pv_d;
      if (pv_d) begin
        pd_q <= pd_d;
        pb_q <= pb_d;
      end
    end
  end

  assign push_valid = pv_q;
  assign push_data  = pd_q;
  assign push_break = pb_q;

  assert_tx_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lbe && tx_wr && !pend_q && !fifo_full) |=>
      push_valid && !push_break && (push_data == $past(tx_data)));

  assert_ext_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lbe && ext_valid && !tx_wr && !brk_edge && !pend_q) |=> !push_valid);

  assert_full_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |=> !push_valid);

  assert_break_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_break && $past(lbe)) |-> (push_data == BRK_DATA));

endmodule

// File: rtl/uart_loopback_ctl.sv
module uart_loopback_ctl
  import ulb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              ctrl_lbe,
  input  logic              ctrl_out1,
  input  logic              ctrl_out2,
  input  logic              ctrl_rts,
  input  logic              ctrl_dtr,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              lcr_wr,
  input  logic              lcr_brk,
  input  logic              ext_valid,
  input  logic [DATA_W-1:0] ext_data,
  input  logic              ext_break,
  input  logic              fifo_full,
  output logic              push_valid,
  output logic [DATA_W-1:0] push_data,
  output logic              push_break,
  output logic              flag_ri,
  output logic              flag_dcd,
  output logic              flag_cts,
  output logic              flag_dsr,
  output logic [3:0]        ms_irq_set,
  output logic [3:0]        ms_irq_clr
);

  logic         lbe_q, lbe_d;
  logic         brk_q, brk_d;
  logic         brk_edge;
  modem_flags_t flags;

  // loopback state and stored send-break bit
  always_comb begin
    lbe_d    = ctrl_wr ? ctrl_lbe : lbe_q;
    brk_d    = lcr_wr  ? lcr_brk  : brk_q;
    brk_edge = lcr_wr && lcr_brk && !brk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lbe_q <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      lbe_q <= lbe_d;
      brk_q <= brk_d;
    end
  end

  ulb_modem_mirror i_mirror (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .ctrl_lbe  (ctrl_lbe),
    .ctrl_out1 (ctrl_out1),
    .ctrl_out2 (ctrl_out2),
    .ctrl_rts  (ctrl_rts),
    .ctrl_dtr  (ctrl_dtr),
    .flags     (flags),
    .ms_set    (ms_irq_set),
    .ms_clr    (ms_irq_clr)
  );

  ulb_push_sel #(.DATA_W(DATA_W)) i_push (
    .clk        (clk),
    .rst_n      (rst_n),
    .lbe        (lbe_q),
    .tx_wr      (tx_wr),
    .tx_data    (tx_data),
    .brk_edge   (brk_edge),
    .ext_valid  (ext_valid),
    .ext_data   (ext_data),
    .ext_break  (ext_break),
    .fifo_full  (fifo_full),
    .push_valid (push_valid),
    .push_data  (push_data),
    .push_break (push_break)
  );

  assign flag_ri  = flags.ri;
  assign flag_dcd = flags.dcd;
  assign flag_cts = flags.cts;
  assign flag_dsr = flags.dsr;

  assert_no_push_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!lbe_q && !ext_valid && $past(!lbe_q)) |=> !push_valid);

  assert_brk_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_wr && lcr_brk && brk_q && !tx_wr && lbe_q && !ext_valid) |=> !(push_valid && push_break));

endmodule

// File: tb/test_uart_loopback_ctl.sv
module test_uart_loopback_ctl;
  localparam int  DW     = 8;
  localparam time CLK_PS = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic ctrl_wr, ctrl_lbe, ctrl_out1, ctrl_out2, ctrl_rts, ctrl_dtr;
  logic tx_wr; logic [DW-1:0] tx_data;
  logic lcr_wr, lcr_brk;
  logic ext_valid; logic [DW-1:0] ext_data; logic ext_break;
  logic fifo_full;
  logic push_valid; logic [DW-1:0] push_data; logic push_break;
  logic flag_ri, flag_dcd, flag_cts, flag_dsr;
  logic [3:0] ms_irq_set, ms_irq_clr;

  int checks = 0;
  int failures = 0;
  logic [3:0] exp_flags = 4'b0; // bit0 RI, bit1 CTS, bit2 DCD, bit3 DSR

  always #(CLK_PS/2) clk = ~clk;

  uart_loopback_ctl #(.DATA_W(DW)) i_uart_loopback_ctl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_lbe(ctrl_lbe),
    .ctrl_out1(ctrl_out1), .ctrl_out2(ctrl_out2), .ctrl_rts(ctrl_rts), .ctrl_dtr(ctrl_dtr),
    .tx_wr(tx_wr), .tx_data(tx_data), .lcr_wr(lcr_wr), .lcr_brk(lcr_brk),
    .ext_valid(ext_valid), .ext_data(ext_data), .ext_break(ext_break), .fifo_full(fifo_full),
    .push_valid(push_valid), .push_data(push_data), .push_break(push_break),
    .flag_ri(flag_ri), .flag_dcd(flag_dcd), .flag_cts(flag_cts), .flag_dsr(flag_dsr),
    .ms_irq_set(ms_irq_set), .ms_irq_clr(ms_irq_clr));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] flag_vec();
    return {flag_dsr, flag_dcd, flag_cts, flag_ri};
  endfunction

  task automatic idle_inputs();
    ctrl_wr = 0; tx_wr = 0; lcr_wr = 0; ext_valid = 0; fifo_full = 0;
  endtask

  // check push port at the current negedge
  task automatic check_push(input string req, input logic v, input logic [DW-1:0] d, input logic b);
    check({req, " valid"}, {31'b0, push_valid}, {31'b0, v});
    if (v) begin
      check({req, " data"}, {24'b0, push_data}, {24'b0, d});
      check({req, " break"}, {31'b0, push_break}, {31'b0, b});
    end
  endtask

  task automatic ctrl_write(input logic [4:0] c); // {lbe,out1,out2,rts,dtr}
    @(negedge clk);
    ctrl_wr = 1; ctrl_lbe = c[4]; ctrl_out1 = c[3]; ctrl_out2 = c[2]; ctrl_rts = c[1]; ctrl_dtr = c[0];
    @(negedge clk);
    idle_inputs();
    if (c[4]) begin
      exp_flags = {c[0], c[3], c[1], c[2]};
      check("R2 flags", {28'b0, flag_vec()}, {28'b0, exp_flags});
      check("R4 clr", {28'b0, ms_irq_clr}, 32'hF);
      check("R4 set", {28'b0, ms_irq_set}, {28'b0, exp_flags});
    end else begin
      check("R3 flags hold", {28'b0, flag_vec()}, {28'b0, exp_flags});
      check("R4 clr idle", {28'b0, ms_irq_clr}, 32'h0);
      check("R4 set idle", {28'b0, ms_irq_set}, 32'h0);
    end
    @(negedge clk);
    check("R4 pulse end", {24'b0, ms_irq_clr, ms_irq_set}, 32'h0);
    check("R3 flags stable", {28'b0, flag_vec()}, {28'b0, exp_flags});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0;
    idle_inputs();
    ctrl_lbe = 0; ctrl_out1 = 0; ctrl_out2 = 0; ctrl_rts = 0; ctrl_dtr = 0;
    tx_data = 0; lcr_brk = 0; ext_data = 0; ext_break = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 flags", {28'b0, flag_vec()}, 32'h0);
    check("R1 irq", {24'b0, ms_irq_set, ms_irq_clr}, 32'h0);
    check("R1 push", {31'b0, push_valid}, 32'h0);
    // R1 loopback off: external entry passes
    ext_valid = 1; ext_data = 8'h5A; ext_break = 0;
    @(negedge clk); idle_inputs();
    check_push("R1 loopback off", 1, 8'h5A, 0);

    // R2/R3/R4: every control combination, twice in different order
    for (int i = 0; i < 32; i++) ctrl_write(i[4:0]);
    for (int i = 31; i >= 0; i--) ctrl_write(i[4:0] ^ 5'b10101);

    // loopback on
    ctrl_write(5'b10000);
    // R5: all transmit bytes
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); tx_wr = 1; tx_data = i[7:0];
      @(negedge clk); idle_inputs();
      check_push("R5 tx loop", 1, i[7:0], 0);
    end
    // R10: tx against full FIFO, then confirm it never comes out
    @(negedge clk); tx_wr = 1; tx_data = 8'hC3; fifo_full = 1;
    @(negedge clk); idle_inputs();
    check_push("R10 tx full", 0, 0, 0);
    @(negedge clk);
    check_push("R10 tx not later", 0, 0, 0);
    // R8: external traffic ignored in loopback
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); ext_valid = 1; ext_data = i[7:0] * 8'd7; ext_break = i[0];
      @(negedge clk); idle_inputs();
      check_push("R8 ext blocked", 0, 0, 0);
    end
    // R6: break edges
    @(negedge clk); lcr_wr = 1; lcr_brk = 1;
    @(negedge clk); idle_inputs();
    check_push("R6 break edge", 1, 8'h00, 1);
    @(negedge clk); lcr_wr = 1; lcr_brk = 1;
    @(negedge clk); idle_inputs();
    check_push("R6 break held", 0, 0, 0);
    @(negedge clk); lcr_wr = 1; lcr_brk = 0;
    @(negedge clk); idle_inputs();
    check_push("R6 break clear", 0, 0, 0);
    // R10: break edge against full FIFO
    @(negedge clk); lcr_wr = 1; lcr_brk = 1; fifo_full = 1;
    @(negedge clk); idle_inputs();
    check_push("R10 break full", 0, 0, 0);
    @(negedge clk); lcr_wr = 1; lcr_brk = 0;
    @(negedge clk); idle_inputs();
    // R7: collision of byte and break edge
    @(negedge clk); tx_wr = 1; tx_data = 8'h9E; lcr_wr = 1; lcr_brk = 1;
    @(negedge clk); idle_inputs();
    check_push("R7 byte first", 1, 8'h9E, 0);
    @(negedge clk);
    check_push("R7 break second", 1, 8'h00, 1);
    @(negedge clk);
    check_push("R7 then idle", 0, 0, 0);
    @(negedge clk); lcr_wr = 1; lcr_brk = 0;
    @(negedge clk); idle_inputs();

    // loopback off, flags hold (R3)
    ctrl_write(5'b01111);
    // R9: external entries pass, transmit and break do not
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); ext_valid = 1; ext_data = i[7:0] ^ 8'hA5; ext_break = i[1];
      @(negedge clk); idle_inputs();
      check_push("R9 ext pass", 1, i[7:0] ^ 8'hA5, i[1]);
    end
    @(negedge clk); tx_wr = 1; tx_data = 8'h11;
    @(negedge clk); idle_inputs();
    check_push("R9 tx no push", 0, 0, 0);
    @(negedge clk); lcr_wr = 1; lcr_brk = 1;
    @(negedge clk); idle_inputs();
    check_push("R9 break no push", 0, 0, 0);
    // R6: stored bit updated while off, so no edge after turning loopback on
    ctrl_write(5'b11111);
    @(negedge clk); lcr_wr = 1; lcr_brk = 1;
    @(negedge clk); idle_inputs();
    check_push("R6 stored bit", 0, 0, 0);
    ctrl_write(5'b00000);
    // R10: external against full FIFO
    @(negedge clk); ext_valid = 1; ext_data = 8'h77; fifo_full = 1;
    @(negedge clk); idle_inputs();
    check_push("R10 ext full", 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule